// File: doc/BRIEF.md
# Codec power-down and reset sequencer

This block sequences power-down, reset and start-up for the two signal paths of a stereo audio codec: the capture path (ADC) and the playback path (DAC). It takes the active-low chip power-down pin, a reset bit and a power bit for each path from the control registers, and a single-cycle frame strobe that marks each audio sample frame. From these it drives path enables, digital filter resets and a gate on the ADC serial data.

The pin is brought into the master clock domain by a two-stage synchronizer. The synchronizer asserts the block's reset at once and releases it on a clock edge. A path runs only while its reset bit and its power bit are both 1. Each time the capture path starts, it must count a fixed number of frames before its data is let through. Until then the output data is forced to zero.

The block also holds the live code of the input attenuator, which belongs to the capture path, and of the output attenuator, which belongs to the playback path. Each code rests at a fixed value while its path is stopped. Once the path runs, the code walks one step per frame toward the programmed target.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `pdn_n` is 0, the block is held in reset with no clock needed: `adc_en`=0, `dac_en`=0, both filter resets 1, `adc_valid`=0, `in_att`=00h and `out_att`=FFh.
- R2: After `pdn_n` rises, reset is released on the second rising clock edge. A path whose bits are already 1 shows its enable on the third edge.
- R3: A path enable equals the AND of that path's reset bit and power bit, registered once. The path's filter reset is the inverse of its enable.
- R4: Once the capture path runs, `adc_valid` rises on the edge that samples the 516th frame strobe counted while the path is running (`ADC_INIT_FRAMES`). It is 0 after 515 strobes.
- R5: If the capture path stops, `adc_valid` falls on the next edge. A full new count of 516 strobes is then needed before it rises again.
- R6: `adc_dout` equals `adc_din` while `adc_valid` is 1 and is all zeros otherwise.
- R7: The playback path's enable and output attenuator are not affected by the capture path's state or its start-up count.
- R8: While the capture path is stopped, `in_att` is 00h. While the playback path is stopped, `out_att` is FFh. Each code is updated on the edge after the path stops.
- R9: While a path runs, each sampled frame strobe moves its attenuator code by one toward the target. The code stays unchanged once it equals the target and in cycles without a strobe.
- R10: A target changed while a path runs is approached from the current code, not from the rest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pdn_n | input | 1 | Chip power-down pin, active low, asynchronous |
| frame_tick | input | 1 | One-cycle strobe per sample frame |
| adc_rst_bit | input | 1 | Capture path reset register bit (0 holds the path in reset) |
| adc_pwr_bit | input | 1 | Capture path power register bit (0 powers the path down) |
| dac_rst_bit | input | 1 | Playback path reset register bit |
| dac_pwr_bit | input | 1 | Playback path power register bit |
| in_att_tgt | input | 8 | Programmed input attenuator code |
| out_att_tgt | input | 8 | Programmed output attenuator code |
| adc_din | input | 24 | Capture data from the decimation filter |
| adc_en | output | 1 | Capture path enable |
| dac_en | output | 1 | Playback path enable |
| adc_filt_rst | output | 1 | Capture filter reset |
| dac_filt_rst | output | 1 | Playback filter reset |
| adc_valid | output | 1 | Capture start-up count complete |
| adc_dout | output | 24 | Gated capture serial data |
| in_att | output | 8 | Live input attenuator code |
| out_att | output | 8 | Live output attenuator code |

## Verification
On every cycle, the assertions check several properties. An attenuator code moves by at most one step, and only on a strobe. It sits at its rest value while its path is stopped. The start-up flag drops after the path stops and rises only on a strobe. The count never passes its limit, and the playback enable follows its own bits. Only the bench scenarios can show the exact frame on which the gate opens, including the 515/516 boundary, and that the count starts again after the path stops. The same holds for the synchronizer delay, the asynchronous hold from the pin, and a fade that is retargeted partway through.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  localparam int unsigned ADC_INIT_FRAMES_DEF = 516;
  localparam int unsigned ATT_W_DEF           = 8;
  localparam int unsigned DATA_W_DEF          = 24;

  typedef struct packed {
    logic en;
    logic filt_rst;
  } path_ctl_t;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/seq_adc_init.sv
module seq_adc_init #(
  parameter int unsigned FRAMES = 516
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic valid
);
  localparam int unsigned CNT_W = $clog2(FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;
  logic             cnt_en;

  assign cnt_en = run && tick && !valid_q;

  always_comb begin
    cnt_d   = cnt_q;
    valid_d = valid_q;
    if (!run) begin
      cnt_d   = '0;
      valid_d = 1'b0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;

  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !valid_q);
  p_open_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> ($past(tick) && $past(run)));
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAMES));
endmodule

// File: rtl/seq_att_fade.sv
module seq_att_fade #(
  parameter int unsigned ATT_W    = 8,
  parameter logic [ATT_W-1:0] REST_CODE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [ATT_W-1:0] tgt,
  output logic [ATT_W-1:0] cur
);
  logic [ATT_W-1:0] cur_q, cur_d;
  logic             step_en;

  assign step_en = run && tick && (cur_q != tgt);

  always_comb begin
    cur_d = cur_q;
    if (!run)          cur_d = REST_CODE;
    else if (step_en)  cur_d = (cur_q < tgt) ? cur_q + 1'b1 : cur_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= REST_CODE;
    else        cur_q <= cur_d;
  end

  assign cur = cur_q;

  p_rest_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(run)) |-> cur_q == REST_CODE);
  p_no_move_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run) && !$past(tick)) |-> $stable(cur_q));
  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run)) |->
      (cur_q == $past(cur_q) || cur_q == ATT_W'($past(cur_q) + 1'b1) ||
       cur_q == ATT_W'($past(cur_q) - 1'b1)));
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_seq_pkg::*;
#(
  parameter int unsigned ADC_INIT_FRAMES = ADC_INIT_FRAMES_DEF,
  parameter int unsigned ATT_W           = ATT_W_DEF,
  parameter int unsigned DATA_W          = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              pdn_n,
  input  logic              frame_tick,
  input  logic              adc_rst_bit,
  input  logic              adc_pwr_bit,
  input  logic              dac_rst_bit,
  input  logic              dac_pwr_bit,
  input  logic [ATT_W-1:0]  in_att_tgt,
  input  logic [ATT_W-1:0]  out_att_tgt,
  input  logic [DATA_W-1:0] adc_din,
  output logic              adc_en,
  output logic              dac_en,
  output logic              adc_filt_rst,
  output logic              dac_filt_rst,
  output logic              adc_valid,
  output logic [DATA_W-1:0] adc_dout,
  output logic [ATT_W-1:0]  in_att,
  output logic [ATT_W-1:0]  out_att
);
  localparam logic [ATT_W-1:0] IN_REST  = '0;
  localparam logic [ATT_W-1:0] OUT_REST = '1;

  logic      rst_n;
  logic      adc_run, dac_run;
  path_ctl_t adc_ctl_q, adc_ctl_d, dac_ctl_q, dac_ctl_d;

  seq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .pin_n (pdn_n),
    .rst_n (rst_n)
  );

  assign adc_run = adc_rst_bit && adc_pwr_bit;
  assign dac_run = dac_rst_bit && dac_pwr_bit;

  always_comb begin
    adc_ctl_d.en       = adc_run;
    adc_ctl_d.filt_rst = !adc_run;
    dac_ctl_d.en       = dac_run;
    dac_ctl_d.filt_rst = !dac_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_ctl_q <= '{en: 1'b0, filt_rst: 1'b1};
      dac_ctl_q <= '{en: 1'b0, filt_rst: 1'b1};
    end else begin
      adc_ctl_q <= adc_ctl_d;
      dac_ctl_q <= dac_ctl_d;
    end
  end

  seq_adc_init #(.FRAMES(ADC_INIT_FRAMES)) u_adc_init (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (adc_run),
    .tick  (frame_tick),
    .valid (adc_valid)
  );

  seq_att_fade #(.ATT_W(ATT_W), .REST_CODE(IN_REST)) u_in_fade (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (adc_run),
    .tick  (frame_tick),
    .tgt   (in_att_tgt),
    .cur   (in_att)
  );

  seq_att_fade #(.ATT_W(ATT_W), .REST_CODE(OUT_REST)) u_out_fade (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (dac_run),
    .tick  (frame_tick),
    .tgt   (out_att_tgt),
    .cur   (out_att)
  );

  assign adc_dout     = adc_valid ? adc_din : '0;
  assign adc_en       = adc_ctl_q.en;
  assign adc_filt_rst = adc_ctl_q.filt_rst;
  assign dac_en       = dac_ctl_q.en;
  assign dac_filt_rst = dac_ctl_q.filt_rst;

  p_dac_follows_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dac_en == $past(dac_rst_bit && dac_pwr_bit));
  p_valid_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid |-> adc_en);
endmodule

// File: tb/codec_pwr_seq_tb.sv
module codec_pwr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NFR = 516;

  logic        clk = 1'b0;
  logic        pdn_n, frame_tick;
  logic        adc_rst_bit, adc_pwr_bit, dac_rst_bit, dac_pwr_bit;
  logic [7:0]  in_att_tgt, out_att_tgt;
  logic [23:0] adc_din;
  logic        adc_en, dac_en, adc_filt_rst, dac_filt_rst, adc_valid;
  logic [23:0] adc_dout;
  logic [7:0]  in_att, out_att;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_pwr_seq u_dut (
    .clk(clk), .pdn_n(pdn_n), .frame_tick(frame_tick),
    .adc_rst_bit(adc_rst_bit), .adc_pwr_bit(adc_pwr_bit),
    .dac_rst_bit(dac_rst_bit), .dac_pwr_bit(dac_pwr_bit),
    .in_att_tgt(in_att_tgt), .out_att_tgt(out_att_tgt), .adc_din(adc_din),
    .adc_en(adc_en), .dac_en(dac_en), .adc_filt_rst(adc_filt_rst),
    .dac_filt_rst(dac_filt_rst), .adc_valid(adc_valid), .adc_dout(adc_dout),
    .in_att(in_att), .out_att(out_att)
  );

  function automatic int observe(int sel);
    case (sel)
      0: return int'(adc_en);
      1: return int'(dac_en);
      2: return int'(adc_filt_rst);
      3: return int'(dac_filt_rst);
      4: return int'(adc_valid);
      5: return int'(adc_dout);
      6: return int'(in_att);
      default: return int'(out_att);
    endcase
  endfunction

  // monitor: compares every queued expectation mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it  = sb.pop_front();
      act = observe(it.sel);
      n_checks++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_val(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1'b1; step(1);
      frame_tick = 1'b0; step(1);
    end
  endtask

  task automatic expect_reset_state(string req);
    expect_val(req, 0, 0); expect_val(req, 1, 0);
    expect_val(req, 2, 1); expect_val(req, 3, 1);
    expect_val(req, 4, 0); expect_val(req, 5, 0);
    expect_val(req, 6, 8'h00); expect_val(req, 7, 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    pdn_n = 0; frame_tick = 0;
    adc_rst_bit = 1; adc_pwr_bit = 1; dac_rst_bit = 1; dac_pwr_bit = 1;
    in_att_tgt = 8'h05; out_att_tgt = 8'hFA; adc_din = 24'hABCDEF;
    step(3);
    expect_reset_state("R1 held by pin");
    step(1);

    // R2: release sequence
    pdn_n = 1;
    step(2);
    expect_val("R2 en held during sync", 0, 0);
    step(1);
    expect_val("R2 en after third edge", 0, 1);
    expect_val("R3 adc filt reset", 2, 0);
    expect_val("R2 dac en", 1, 1);

    // R9: fade in on both paths
    frames(3);
    expect_val("R9 in att after 3 frames", 6, 3);
    expect_val("R9 out att after 3 frames", 7, 8'hFC);
    step(4);
    expect_val("R9 no step without tick", 6, 3);
    frames(7);
    expect_val("R9 in att stops at target", 6, 5);
    expect_val("R9 out att stops at target", 7, 8'hFA);

    // R4/R6: start-up gate boundary
    frames(NFR - 1 - 10);
    expect_val("R4 not valid after 515", 4, 0);
    expect_val("R6 data gated", 5, 0);
    frames(1);
    expect_val("R4 valid after 516", 4, 1);
    expect_val("R6 data passes", 5, 24'hABCDEF);

    // R10: retarget from current code
    in_att_tgt = 8'h02;
    frames(1);
    expect_val("R10 fade from current", 6, 4);

    // R5/R7/R8: stop capture path via power bit
    adc_pwr_bit = 0;
    step(1);
    expect_val("R5 valid drops", 4, 0);
    expect_val("R3 adc en off", 0, 0);
    expect_val("R3 adc filt reset on", 2, 1);
    expect_val("R8 in att rest", 6, 0);
    expect_val("R7 dac en kept", 1, 1);
    expect_val("R7 out att kept", 7, 8'hFA);
    adc_pwr_bit = 1;
    frames(NFR - 1);
    expect_val("R5 recount not done at 515", 4, 0);
    expect_val("R7 dac unaffected during count", 3, 0);
    frames(1);
    expect_val("R5 recount done at 516", 4, 1);

    // R8: playback stopped by reset bit
    dac_rst_bit = 0;
    step(1);
    expect_val("R8 out att rest", 7, 8'hFF);
    expect_val("R3 dac en off", 1, 0);
    expect_val("R8 adc still valid", 4, 1);
    step(1);

    // R1: asynchronous hold from pin
    #2 pdn_n = 0;
    #1;
    expect_reset_state("R1 async");
    step(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule